// File: doc/BRIEF.md
# UDP Payload Encapsulator

This block sits behind a UDP offload stage and turns the bare payload stream it produces into network packets made of 128-bit words. The input is a 32-bit streaming sink with valid, ready, start and end markers; on the start beat the offload stage also presents the payload byte count taken from the UDP length field and the destination port. Every packet leaves as one header word, the packed payload words, and one footer word. The output uses a valid/ready handshake with its own start and end markers.

The byte count, not the input end marker, decides where a payload ends. Four input beats fill one output word, with the earliest beat in the lowest lane. Bytes past the count are forced to zero. A payload longer than 256 output words is cut at that limit. The beats beyond it are still consumed and then dropped, and the footer reports the cut. Back-pressure on the output stalls the input through its ready signal, so no beat is lost and none is repeated.

Top module: `udp_encap`

## Requirements
- R1: While reset is held and right after it is released, out_valid and in_ready are low (with in_valid low).
- R2: The first word of each packet carries out_sop and holds the header: bits [12:0] the payload byte count after any truncation, bits [31:16] the destination port captured on the start beat, bits [63:32] the packet sequence number, and zero in all other bits.
- R3: Payload byte i of a packet appears in payload word i/16, in bits [8*(i%16)+7 : 8*(i%16)]. Input beat k carries bytes 4k to 4k+3, with the lowest-numbered byte in bits [7:0].
- R4: Every byte at or past the byte count is zero in the payload words. This covers the unused bytes of a partial last beat and the unfilled lanes of a partial last word. The number of payload words is ceil(count/16).
- R5: The last word of each packet carries out_eop and holds the footer: bits [15:0] the number of payload words sent, bit 16 the truncation flag, bit 17 the end-marker mismatch flag, bits [63:32] the constant 0xE0F0C0DE, and zero elsewhere. It follows the last payload word.
- R6: A byte count above 4096 gives exactly 256 payload words and a header count of 4096, and sets footer bit 16. All ceil(count/4) input beats are still accepted.
- R7: While out_valid is high and out_ready is low, the output word and its markers hold steady. Under any pattern of output and input stalls, every payload byte is delivered exactly once.
- R8: The sequence number is 0 for the first packet after reset and goes up by one for each packet.
- R9: The packet ends after ceil(count/4) beats whatever in_eop does. Footer bit 17 is set when in_eop is high on a beat other than the last one, or low on the last one.
- R10: A beat without in_sop that arrives between packets is accepted and dropped, and produces no output.
- R11: Each packet has exactly one word with out_sop (the first) and one with out_eop (the last), and no payload word carries either marker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with in_valid |
| in_data | input | IN_W | Payload beat, lowest byte first |
| in_sop | input | 1 | First beat of a payload |
| in_eop | input | 1 | Input end marker (checked, not used for framing) |
| in_len | input | LEN_W | Payload byte count, valid with the start beat |
| in_dport | input | 16 | Destination port, valid with the start beat |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream ready |
| out_data | output | OUT_W | Header, payload or footer word |
| out_sop | output | 1 | Header word marker |
| out_eop | output | 1 | Footer word marker |

## Verification
The bench aims at byte counts that end inside a beat and inside a word (1, 17, 21 bytes). A design that got these wrong would leak stale or non-zero filler bytes, or give a wrong word count. It sends a packet of exactly 4096 bytes and one of 4100 bytes. An off-by-one limit would either set the truncation flag on the exact-size packet or let a 257th word through. It sends an early end marker, a missing end marker and a stray beat between packets. A design that framed on in_eop would cut packets short or turn stray beats into output. Random output stalls and input gaps test whether the drain of a full word and the fill of the next word in the same cycle ever loses or repeats a beat.

// File: rtl/encap_pkg.sv
package encap_pkg;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_HDR,
      ST_BODY,
      ST_FTR
   } encap_state_e;

   // header field placement
   localparam int HDR_PORT_LSB = 16;
   localparam int HDR_SEQ_LSB  = 32;

   // footer field placement
   localparam int FTR_OVF_BIT  = 16;
   localparam int FTR_MISM_BIT = 17;
   localparam int FTR_MARK_LSB = 32;

   localparam logic [31:0] END_MARK = 32'hE0F0_C0DE;

endpackage

// File: rtl/encap_len_track.sv
module encap_len_track #(
   parameter int IN_W      = 32,
   parameter int LEN_W     = 16,
   parameter int CAP_BEATS = 1024,
   parameter int CNT_W     = 13
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load,
   input  logic [LEN_W-1:0]     len_in,
   input  logic                 beat_fire,
   output logic                 last_beat,
   output logic                 keep_beat,
   output logic                 cap_beat,
   output logic                 over,
   output logic [IN_W/8-1:0]    byte_keep,
   output logic [CNT_W-1:0]     hdr_bytes
);
   localparam int BPB       = IN_W / 8;
   localparam int BSEL      = $clog2(BPB);
   localparam int CAP_BYTES = CAP_BEATS * BPB;

   logic [LEN_W-1:0] len_r;
   logic [LEN_W-1:0] beats_left;
   logic [LEN_W-1:0] beat_idx;
   logic [LEN_W-1:0] beats_tot;
   logic [BSEL-1:0]  rem;

   assign beats_tot = (len_in >> BSEL)
                    + {{(LEN_W-1){1'b0}}, |len_in[BSEL-1:0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         len_r      <= '0;
         beats_left <= '0;
         beat_idx   <= '0;
      end else if (load) begin
         len_r      <= len_in;
         beats_left <= beats_tot;
         beat_idx   <= '0;
      end else if (beat_fire) begin
         beats_left <= beats_left - 1'b1;
         beat_idx   <= beat_idx + 1'b1;
      end
   end

   assign rem       = len_r[BSEL-1:0];
   assign last_beat = (beats_left == LEN_W'(1));
   assign keep_beat = (beat_idx < LEN_W'(CAP_BEATS));
   assign cap_beat  = (beat_idx == LEN_W'(CAP_BEATS - 1));
   assign over      = (len_r > LEN_W'(CAP_BYTES));
   assign hdr_bytes = over ? CNT_W'(CAP_BYTES) : len_r[CNT_W-1:0];

   for (genvar j = 0; j < BPB; j++) begin : g_bmask
      assign byte_keep[j] = !last_beat || (rem == '0) || (BSEL'(j) < rem);
   end

endmodule

// File: rtl/encap_packer.sv
module encap_packer #(
   parameter int IN_W  = 32,
   parameter int OUT_W = 128
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             push,
   input  logic             seal,
   input  logic             pop,
   input  logic [IN_W-1:0]  beat,
   output logic [OUT_W-1:0] word,
   output logic             full
);
   localparam int LANES = OUT_W / IN_W;
   localparam int LSEL  = $clog2(LANES);

   logic [LSEL-1:0] lane;
   logic            close;
   logic [IN_W-1:0] slot [LANES];

   assign close = push && (seal || lane == LSEL'(LANES - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lane <= '0;
         full <= 1'b0;
      end else if (clear) begin
         lane <= '0;
         full <= 1'b0;
      end else begin
         if (push) lane <= close ? '0 : lane + 1'b1;
         if (close)    full <= 1'b1;
         else if (pop) full <= 1'b0;
      end
   end

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                slot[l] <= '0;
         else if (clear)                            slot[l] <= '0;
         else if (push && lane == LSEL'(l))         slot[l] <= beat;
         else if (pop)                              slot[l] <= '0;
      end
      assign word[l*IN_W +: IN_W] = slot[l];
   end

endmodule

// File: rtl/udp_encap.sv
module udp_encap
   import encap_pkg::*;
#(
   parameter int IN_W      = 32,
   parameter int OUT_W     = 128,
   parameter int LEN_W     = 16,
   parameter int MAX_WORDS = 256
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [IN_W-1:0]  in_data,
   input  logic             in_sop,
   input  logic             in_eop,
   input  logic [LEN_W-1:0] in_len,
   input  logic [15:0]      in_dport,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [OUT_W-1:0] out_data,
   output logic             out_sop,
   output logic             out_eop
);
   localparam int LANES     = OUT_W / IN_W;
   localparam int BPB       = IN_W / 8;
   localparam int CAP_BEATS = MAX_WORDS * LANES;
   localparam int CAP_BYTES = MAX_WORDS * (OUT_W / 8);
   localparam int CNT_W     = $clog2(CAP_BYTES + 1);
   localparam int WCNT_W    = $clog2(MAX_WORDS + 1);

   initial begin
      assert (IN_W % 8 == 0 && IN_W >= 16)
         else $fatal(1, "IN_W must be whole bytes, at least 16");
      assert (OUT_W % IN_W == 0 && LANES >= 2)
         else $fatal(1, "OUT_W must hold two or more input beats");
      assert (OUT_W >= FTR_MARK_LSB + 32)
         else $fatal(1, "OUT_W too narrow for header and footer fields");
      assert (CNT_W <= HDR_PORT_LSB && WCNT_W <= FTR_OVF_BIT)
         else $fatal(1, "MAX_WORDS too large for the count fields");
      assert (CAP_BEATS < (1 << LEN_W))
         else $fatal(1, "LEN_W too narrow for MAX_WORDS");
   end

   encap_state_e state, nstate;

   logic              load, beat_fire, ftr_fire, hdr_fire;
   logic              last_beat, keep_beat, cap_beat, over;
   logic [BPB-1:0]    byte_keep;
   logic [CNT_W-1:0]  hdr_bytes;
   logic [IN_W-1:0]   beat_m;
   logic [OUT_W-1:0]  pk_word;
   logic              pk_full, pk_pop;
   logic              in_done, mism;
   logic [WCNT_W-1:0] wcnt;
   logic [31:0]       seq_r;
   logic [15:0]       dport_r;
   logic [OUT_W-1:0]  hdr_w, ftr_w;

   assign load      = (state == ST_IDLE) && in_valid && in_sop;
   assign in_ready  = ((state == ST_IDLE) && in_valid && !in_sop)
                    || ((state == ST_BODY) && !in_done && (!pk_full || out_ready));
   assign beat_fire = (state == ST_BODY) && in_valid && in_ready;
   assign pk_pop    = (state == ST_BODY) && pk_full && out_ready;
   assign hdr_fire  = (state == ST_HDR) && out_ready;
   assign ftr_fire  = (state == ST_FTR) && out_ready;

   encap_len_track #(
      .IN_W      (IN_W),
      .LEN_W     (LEN_W),
      .CAP_BEATS (CAP_BEATS),
      .CNT_W     (CNT_W)
   ) u_len (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .len_in    (in_len),
      .beat_fire (beat_fire),
      .last_beat (last_beat),
      .keep_beat (keep_beat),
      .cap_beat  (cap_beat),
      .over      (over),
      .byte_keep (byte_keep),
      .hdr_bytes (hdr_bytes)
   );

   for (genvar j = 0; j < BPB; j++) begin : g_mask
      assign beat_m[8*j +: 8] = in_data[8*j +: 8] & {8{byte_keep[j]}};
   end

   encap_packer #(
      .IN_W  (IN_W),
      .OUT_W (OUT_W)
   ) u_pack (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (load),
      .push  (beat_fire && keep_beat),
      .seal  (last_beat || cap_beat),
      .pop   (pk_pop),
      .beat  (beat_m),
      .word  (pk_word),
      .full  (pk_full)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_done <= 1'b0;
         mism    <= 1'b0;
         wcnt    <= '0;
         seq_r   <= '0;
         dport_r <= '0;
      end else begin
         if (load) begin
            in_done <= 1'b0;
            mism    <= 1'b0;
            wcnt    <= '0;
            dport_r <= in_dport;
         end else begin
            if (beat_fire && last_beat)              in_done <= 1'b1;
            if (beat_fire && (in_eop != last_beat))  mism    <= 1'b1;
            if (pk_pop)                              wcnt    <= wcnt + 1'b1;
         end
         if (ftr_fire) seq_r <= seq_r + 1'b1;
      end
   end

   always_comb begin
      nstate = state;
      case (state)
         ST_IDLE: if (load)                  nstate = ST_HDR;
         ST_HDR:  if (hdr_fire)              nstate = ST_BODY;
         ST_BODY: if (in_done && !pk_full)   nstate = ST_FTR;
         ST_FTR:  if (ftr_fire)              nstate = ST_IDLE;
         default:                            nstate = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= nstate;
   end

   always_comb begin
      hdr_w = '0;
      hdr_w[CNT_W-1:0]            = hdr_bytes;
      hdr_w[HDR_PORT_LSB +: 16]   = dport_r;
      hdr_w[HDR_SEQ_LSB +: 32]    = seq_r;
      ftr_w = '0;
      ftr_w[WCNT_W-1:0]           = wcnt;
      ftr_w[FTR_OVF_BIT]          = over;
      ftr_w[FTR_MISM_BIT]         = mism;
      ftr_w[FTR_MARK_LSB +: 32]   = END_MARK;
   end

   always_comb begin
      case (state)
         ST_HDR:  out_data = hdr_w;
         ST_FTR:  out_data = ftr_w;
         default: out_data = pk_word;
      endcase
   end

   assign out_valid = (state == ST_HDR) || (state == ST_FTR)
                    || ((state == ST_BODY) && pk_full);
   assign out_sop   = (state == ST_HDR);
   assign out_eop   = (state == ST_FTR);

endmodule

// File: rtl/udp_encap_chk.sv
module udp_encap_chk #(
   parameter int OUT_W     = 128,
   parameter int MAX_WORDS = 256
)(
   input logic             clk,
   input logic             rst_n,
   input logic             out_valid,
   input logic             out_ready,
   input logic [OUT_W-1:0] out_data,
   input logic             out_sop,
   input logic             out_eop
);
   localparam int PC_W = $clog2(MAX_WORDS + 2);

   logic            in_pkt;
   logic [PC_W-1:0] pay_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_pkt  <= 1'b0;
         pay_cnt <= '0;
      end else if (out_valid && out_ready) begin
         if (out_sop) begin
            in_pkt  <= 1'b1;
            pay_cnt <= '0;
         end else if (out_eop) begin
            in_pkt  <= 1'b0;
         end else begin
            pay_cnt <= pay_cnt + 1'b1;
         end
      end
   end

   // R7
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data)
                                  && $stable(out_sop) && $stable(out_eop));

   // R11
   sop_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !in_pkt |-> out_sop);

   // R11
   single_sop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && in_pkt |-> !out_sop);

   // R6
   word_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && in_pkt && !out_eop |-> pay_cnt < PC_W'(MAX_WORDS));

   // R5
   eop_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_ready && out_eop |=> !out_valid || out_sop);

endmodule

bind udp_encap udp_encap_chk #(
   .OUT_W     (OUT_W),
   .MAX_WORDS (MAX_WORDS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_data  (out_data),
   .out_sop   (out_sop),
   .out_eop   (out_eop)
);

// File: tb/udp_encap_test.sv
module udp_encap_test;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic         in_ready;
   logic [31:0]  in_data = '0;
   logic         in_sop = 1'b0;
   logic         in_eop = 1'b0;
   logic [15:0]  in_len = '0;
   logic [15:0]  in_dport = '0;
   logic         out_valid;
   logic         out_ready = 1'b1;
   logic [127:0] out_data;
   logic         out_sop;
   logic         out_eop;

   always #5 clk = ~clk;

   udp_encap uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .in_data   (in_data),
      .in_sop    (in_sop),
      .in_eop    (in_eop),
      .in_len    (in_len),
      .in_dport  (in_dport),
      .out_valid (out_valid),
      .out_ready (out_ready),
      .out_data  (out_data),
      .out_sop   (out_sop),
      .out_eop   (out_eop)
   );

   logic [127:0] q_data [$];
   logic [1:0]   q_flag [$];
   string        q_tag  [$];

   int  n_cmp = 0;
   int  n_bad = 0;
   int  seq_exp = 0;
   int  pid = 0;
   bit  bp_on = 0;
   bit  gap_on = 0;
   bit  ended = 0;

   task automatic summary();
      if (!ended) begin
         ended = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   // output ready pattern, changed just after each edge
   always @(posedge clk) begin
      #1;
      out_ready = bp_on ? (($urandom % 3) != 0) : 1'b1;
   end

   // scoreboard monitor: a transfer seen at the falling edge completes on the next rising edge
   always @(negedge clk) begin
      if (rst_n && out_valid && out_ready) begin
         n_cmp++;
         if (q_data.size() == 0) begin
            n_bad++;
            $display("FAIL R11 unexpected word act=%h sop=%b eop=%b exp=none",
                     out_data, out_sop, out_eop);
         end else begin
            logic [127:0] ed;
            logic [1:0]   ef;
            string        et;
            ed = q_data.pop_front();
            ef = q_flag.pop_front();
            et = q_tag.pop_front();
            if (out_data !== ed || {out_sop, out_eop} !== ef) begin
               n_bad++;
               $display("FAIL %s (R11 markers) act=%h sop/eop=%b exp=%h sop/eop=%b",
                        et, out_data, {out_sop, out_eop}, ed, ef);
            end
         end
      end
   end

   function automatic logic [7:0] pbyte(int p, int i);
      return 8'((p * 37 + i * 7 + 1) & 255);
   endfunction

   // caller is just past a rising edge
   task automatic drive_beat(logic [31:0] d, bit sop, bit eop, int len, logic [15:0] port);
      bit acc;
      in_valid = 1'b1;
      in_data  = d;
      in_sop   = sop;
      in_eop   = eop;
      in_len   = 16'(len);
      in_dport = port;
      forever begin
         @(negedge clk);
         acc = in_ready;
         @(posedge clk);
         #1;
         if (acc) break;
      end
      in_valid = 1'b0;
      in_sop   = 1'b0;
      in_eop   = 1'b0;
      if (gap_on && ($urandom % 4) == 0) begin
         @(posedge clk);
         #1;
      end
   endtask

   task automatic send_pkt(int len, logic [15:0] port, int eop_at, string tag);
      int nbeats, kept, words;
      bit ovf, mis;
      logic [127:0] w;
      logic [31:0]  d;
      nbeats = (len + 3) / 4;
      ovf    = (len > 4096);
      kept   = ovf ? 4096 : len;
      words  = (kept + 15) / 16;
      mis    = (eop_at != nbeats - 1);
      // R2 R8 header
      w = '0;
      w[12:0]  = 13'(kept);
      w[31:16] = port;
      w[63:32] = 32'(seq_exp);
      q_data.push_back(w); q_flag.push_back(2'b10); q_tag.push_back({tag, " R2/R8 header"});
      // R3 R4 payload words
      for (int wi = 0; wi < words; wi++) begin
         w = '0;
         for (int k = 0; k < 16; k++)
            if (wi * 16 + k < kept) w[8*k +: 8] = pbyte(pid, wi * 16 + k);
         q_data.push_back(w); q_flag.push_back(2'b00);
         q_tag.push_back($sformatf("%s R3/R4 word %0d", tag, wi));
      end
      // R5 footer
      w = '0;
      w[15:0]  = 16'(words);
      w[16]    = ovf;
      w[17]    = mis;
      w[63:32] = 32'hE0F0_C0DE;
      q_data.push_back(w); q_flag.push_back(2'b01); q_tag.push_back({tag, " R5 footer"});
      seq_exp++;
      for (int b = 0; b < nbeats; b++) begin
         for (int j = 0; j < 4; j++)
            d[8*j +: 8] = (b * 4 + j < len) ? pbyte(pid, b * 4 + j) : 8'hAA;
         drive_beat(d, b == 0, b == eop_at, len, port);
      end
      pid++;
   endtask

   task automatic drain();
      while (q_data.size() != 0) @(posedge clk);
      repeat (4) @(posedge clk);
      #1;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 during reset
      n_cmp++;
      if (out_valid !== 1'b0 || in_ready !== 1'b0) begin
         n_bad++;
         $display("FAIL R1 in reset act=%b%b exp=00", out_valid, in_ready);
      end
      @(posedge clk); #1;
      rst_n = 1'b1;
      @(negedge clk);
      // R1 after release
      n_cmp++;
      if (out_valid !== 1'b0 || in_ready !== 1'b0) begin
         n_bad++;
         $display("FAIL R1 after reset act=%b%b exp=00", out_valid, in_ready);
      end
      @(posedge clk); #1;

      send_pkt(64, 16'h1234, 15, "R3 full words");
      send_pkt(1, 16'h0001, 0, "R4 one byte");
      send_pkt(21, 16'hBEEF, 5, "R4 partial beat");
      drain();
      send_pkt(4096, 16'h0F0F, 1023, "R6 exact cap");
      send_pkt(4100, 16'hA5A5, 1024, "R6 truncated");
      drain();
      // R9 early end marker: 30 bytes = 8 beats, eop on beat 2
      send_pkt(30, 16'h0009, 2, "R9 early eop");
      // R9 end marker never given
      send_pkt(48, 16'h000A, 99, "R9 missing eop");
      drain();
      // R10 stray beat between packets must produce nothing
      drive_beat(32'hDEADBEEF, 0, 1, 0, 16'h0);
      send_pkt(17, 16'h0017, 4, "R10 after stray");
      drain();
      // R7 output stalls and input gaps
      bp_on  = 1;
      gap_on = 1;
      send_pkt(50, 16'h0050, 12, "R7 stall");
      send_pkt(33, 16'h0033, 8, "R7 stall");
      send_pkt(100, 16'h0100, 24, "R7 stall");
      send_pkt(4100, 16'h4100, 1024, "R7 R6 stall");
      drain();
      bp_on  = 0;
      gap_on = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R5 nothing after the last footer
      n_cmp++;
      if (out_valid !== 1'b0 || q_data.size() != 0) begin
         n_bad++;
         $display("FAIL R5 trailing output act=%b exp=0 pending=%0d", out_valid, q_data.size());
      end
      summary();
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog act=running exp=finished pending=%0d", q_data.size());
      summary();
   end

endmodule